// File: doc/BRIEF.md
# Signed Double-Width Pair Divider

This block divides a signed dividend of twice the word width by a signed one-word divisor. It returns a one-word signed quotient and a one-word signed remainder, aimed at a pair of registers. The remainder goes to the even register of the pair and the quotient to the odd register. Internally it works on magnitudes with a restoring shift-subtract loop that retires one quotient bit per clock. The signs are applied on the way out.

A request is taken with a single-cycle `start` pulse while the block is idle. The operands and the target register number are captured on that edge. Two conditions are known as soon as the operands arrive: an odd register number, and a quotient that is certain to be too wide. Either one sends the block straight to its completion cycle, without running the loop.

`done` marks the completion cycle. In that cycle the block raises either `wrEn` with the result, or exactly one exception flag, and never both. A divisor of zero and a quotient that does not fit the signed word are both reported as the divide exception. When any exception is reported, no write is requested.

Top module: `pairDivider`

## Requirements
- R1: With `wrEn` high, `quoOut` equals dividend / divisor truncated toward zero, as a W-bit two's-complement value. Its sign follows the algebraic rule, and a zero quotient is all zero bits.
- R2: With `wrEn` high, `remOut` equals dividend minus quotient times divisor. It carries the sign of the dividend, and a zero remainder is all zero bits.
- R3: If the true quotient lies outside [-2^(W-1), 2^(W-1)-1], `divExc` is high and `wrEn` low in the completion cycle. This includes +2^(W-1), for example dividend -2^(W-1) divided by -1.
- R4: A zero divisor with an even register number raises `divExc` with `wrEn` low.
- R5: An odd register number (bit 0 of `regNum` is 1) raises `specExc` with `divExc` and `wrEn` low, whatever the operands.
- R6: `wrEn`, `divExc` and `specExc` are high only while `done` is high, and at most one of them is high. `quoOut` and `remOut` are zero whenever `wrEn` is low.
- R7: In the completion cycle, `remIdx` equals the captured `regNum` and `quoIdx` equals the captured `regNum` with bit 0 set.
- R8: `done` is high for exactly one cycle. Call the `start` edge the edge at which `start` is accepted. When `regNum` is odd, or when |dividend| >> W is at least |divisor|, `done` is high in the cycle after the `start` edge. Otherwise it is high W+1 cycles after the `start` edge.
- R9: `busy` is high from the cycle after the `start` edge through the completion cycle. A `start` seen while `busy` is high is ignored and does not alter the running result.
- R10: After reset, `busy`, `done`, `wrEn`, `divExc` and `specExc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted while idle |
| dividend | input | 2*W | Signed dividend |
| divisor | input | W | Signed divisor |
| regNum | input | RW | Even register number of the target pair |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Completion cycle |
| wrEn | output | 1 | Write the pair; no exception |
| quoOut | output | W | Signed quotient for the odd register |
| remOut | output | W | Signed remainder for the even register |
| remIdx | output | RW | Register number taking the remainder |
| quoIdx | output | RW | Register number taking the quotient |
| divExc | output | 1 | Quotient overflow or zero divisor |
| specExc | output | 1 | Odd register number |

## Verification
The bench uses an 8-bit word and pairs every divisor value, zero included, with a set of dividends. These are the extreme values, zero and ±1, the exact multiples of the divisor at quotients 127, 128, -128 and -129, and pseudo-random values. The multiples separate the late overflow case, found only after the loop has run, from the last quotients that still fit, and they check the asymmetric limit between negative and positive quotients. The extreme dividends and the zero divisor drive the early exit, and its latency shows apart from the full loop. Odd register numbers combined with overflowing and zero divisors show that the register check takes priority, and `start` pulses given mid-run show that a busy block ignores them.

// File: rtl/pairdiv_pkg.sv
package pairdiv_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } divStrobes_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } divState_e;
endpackage

// File: rtl/pairDivControl.sv
module pairDivControl
  import pairdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        skipRun,
  output divStrobes_t strobes,
  output logic        busy
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LastStep = CW'(W - 1);

  divState_e state, nextState;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobes.load   = (state == S_IDLE) && start;
    strobes.step   = (state == S_RUN);
    strobes.finish = (state == S_FIN);
    busy           = (state != S_IDLE);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (start) nextState = skipRun ? S_FIN : S_RUN;
      S_RUN:   if (stepCnt == LastStep) nextState = S_FIN;
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state <= nextState;
      if (strobes.load)      stepCnt <= '0;
      else if (strobes.step) stepCnt <= stepCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pairDivDatapath.sv
module pairDivDatapath
  import pairdiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobes_t   strobes,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]  divisor,
  input  logic [RW-1:0] regNum,
  output logic          skipRun,
  output logic          wrEn,
  output logic [W-1:0]  quoOut,
  output logic [W-1:0]  remOut,
  output logic [RW-1:0] remIdx,
  output logic [RW-1:0] quoIdx,
  output logic          divExc,
  output logic          specExc
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] NegLimit = {1'b1, {(W-1){1'b0}}};

  logic [DW-1:0] absDvdIn;
  logic [W-1:0]  absDvsIn;
  logic          ovfIn;

  logic [W-1:0]  remMag, quoMag, dvsMag;
  logic          dvdNeg, dvsNeg, specFlag, ovfFlag;
  logic [RW-1:0] regLatch;

  logic [W:0]    trial;
  logic          fits;
  logic          qNeg, lateOvf, anyExc;

  // magnitudes of the incoming operands and the early checks
  always_comb begin
    absDvdIn = dividend[DW-1] ? (~dividend + 1'b1) : dividend;
    absDvsIn = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
    ovfIn    = (absDvdIn[DW-1:W] >= absDvsIn);
    skipRun  = regNum[0] | ovfIn;
  end

  // one restoring step
  always_comb begin
    trial = {remMag, quoMag[W-1]};
    fits  = (trial >= {1'b0, dvsMag});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remMag   <= '0;
      quoMag   <= '0;
      dvsMag   <= '0;
      dvdNeg   <= 1'b0;
      dvsNeg   <= 1'b0;
      specFlag <= 1'b0;
      ovfFlag  <= 1'b0;
      regLatch <= '0;
    end else if (strobes.load) begin
      remMag   <= absDvdIn[DW-1:W];
      quoMag   <= absDvdIn[W-1:0];
      dvsMag   <= absDvsIn;
      dvdNeg   <= dividend[DW-1];
      dvsNeg   <= divisor[W-1];
      specFlag <= regNum[0];
      ovfFlag  <= ovfIn;
      regLatch <= regNum;
    end else if (strobes.step) begin
      remMag <= fits ? W'(trial - {1'b0, dvsMag}) : trial[W-1:0];
      quoMag <= {quoMag[W-2:0], fits};
    end
  end

  // sign application and the signed-range check on the finished magnitude
  always_comb begin
    qNeg    = dvdNeg ^ dvsNeg;
    lateOvf = qNeg ? (quoMag > NegLimit) : quoMag[W-1];
    anyExc  = specFlag | ovfFlag | lateOvf;
    specExc = strobes.finish & specFlag;
    divExc  = strobes.finish & ~specFlag & (ovfFlag | lateOvf);
    wrEn    = strobes.finish & ~anyExc;
    quoOut  = wrEn ? (qNeg   ? (~quoMag + 1'b1) : quoMag) : '0;
    remOut  = wrEn ? (dvdNeg ? (~remMag + 1'b1) : remMag) : '0;
    remIdx  = regLatch;
    quoIdx  = {regLatch[RW-1:1], 1'b1};
  end
endmodule

// File: rtl/pairDivider.sv
module pairDivider
  import pairdiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]  divisor,
  input  logic [RW-1:0] regNum,
  output logic          busy,
  output logic          done,
  output logic          wrEn,
  output logic [W-1:0]  quoOut,
  output logic [W-1:0]  remOut,
  output logic [RW-1:0] remIdx,
  output logic [RW-1:0] quoIdx,
  output logic          divExc,
  output logic          specExc
);
  divStrobes_t strobes;
  logic        skipRun;

  pairDivControl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .skipRun(skipRun),
    .strobes(strobes), .busy(busy)
  );

  pairDivDatapath #(.W(W), .RW(RW)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dividend(dividend), .divisor(divisor), .regNum(regNum),
    .skipRun(skipRun), .wrEn(wrEn), .quoOut(quoOut), .remOut(remOut),
    .remIdx(remIdx), .quoIdx(quoIdx), .divExc(divExc), .specExc(specExc)
  );

  assign done = strobes.finish;
endmodule

// File: rtl/pairDividerChecker.sv
module pairDividerChecker #(
  parameter int W  = 32,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [2*W-1:0] dividend,
  input logic [W-1:0]  divisor,
  input logic [RW-1:0] regNum,
  input logic          busy,
  input logic          done,
  input logic          wrEn,
  input logic [W-1:0]  quoOut,
  input logic [W-1:0]  remOut,
  input logic [RW-1:0] remIdx,
  input logic [RW-1:0] quoIdx,
  input logic          divExc,
  input logic          specExc
);
  logic          capDvdNeg, capDvsNeg;
  logic [RW-1:0] capReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDvdNeg <= 1'b0;
      capDvsNeg <= 1'b0;
      capReg    <= '0;
    end else if (start && !busy) begin
      capDvdNeg <= dividend[2*W-1];
      capDvsNeg <= divisor[W-1];
      capReg    <= regNum;
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_write_clean: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (done && !divExc && !specExc));
  a_r6_exc_in_done: assert property (@(posedge clk) disable iff (!rstN)
    (divExc || specExc) |-> (done && !(divExc && specExc)));
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r5_odd_flags: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (specExc == capReg[0]));
  a_r2_rem_sign: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && remOut != '0) |-> (remOut[W-1] == capDvdNeg));
  a_r1_quo_sign: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && quoOut != '0) |-> (quoOut[W-1] == (capDvdNeg ^ capDvsNeg)));
  a_r7_pair_idx: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (remIdx == capReg && quoIdx == (capReg | RW'(1))));
endmodule

bind pairDivider pairDividerChecker #(.W(W), .RW(RW)) uChk (.*);

// File: tb/tb_pairDivider.sv
module tb_pairDivider;
  localparam int W  = 8;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]  divisor = '0;
  logic [RW-1:0] regNum = '0;
  logic          busy, done, wrEn, divExc, specExc;
  logic [W-1:0]  quoOut, remOut;
  logic [RW-1:0] remIdx, quoIdx;

  int vecCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  pairDivider #(.W(W), .RW(RW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .regNum(regNum), .busy(busy), .done(done),
    .wrEn(wrEn), .quoOut(quoOut), .remOut(remOut), .remIdx(remIdx),
    .quoIdx(quoIdx), .divExc(divExc), .specExc(specExc)
  );

  task automatic mis(input string req, input string what, input longint act, input longint exp, inout bit bad);
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    bad = 1'b1;
  endtask

  task automatic runOp(input logic signed [15:0] a, input logic signed [7:0] b,
                       input logic [RW-1:0] r, input bit poke);
    longint la, lb, absA, absB, q, rm;
    bit expSpec, expDiv, expWr, early, bad;
    int expLat, lat;
    la = longint'(a);
    lb = longint'(b);
    absA = (la < 0) ? -la : la;
    absB = (lb < 0) ? -lb : lb;
    expSpec = r[0];
    expDiv = 1'b0;
    q = 0; rm = 0;
    if (!expSpec) begin
      if (lb == 0) expDiv = 1'b1;
      else begin
        q = la / lb;
        rm = la % lb;
        if (q > 127 || q < -128) expDiv = 1'b1;
      end
    end
    expWr = !expSpec && !expDiv;
    if (!expWr) begin q = 0; rm = 0; end
    early = expSpec || ((absA >> W) >= absB);
    expLat = early ? 1 : W + 1;
    bad = 1'b0;
    @(negedge clk);
    dividend = a; divisor = b; regNum = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (poke) begin
      // R9: a start while busy must not disturb the result
      start = 1'b1; dividend = ~a; divisor = b + 8'sd3; regNum = r ^ 4'd2;
    end
    while (!done && lat < 40) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    start = 1'b0;
    vecCount++;
    if (!done) mis("R8", "done never seen", 0, 1, bad);
    else begin
      if (lat != expLat) mis("R8", "latency", lat, expLat, bad);
      if (!busy) mis("R9", "busy in done cycle", busy, 1, bad);
      if (specExc != expSpec) mis("R5", "specExc", specExc, expSpec, bad);
      if (divExc != expDiv) mis((lb == 0) ? "R4" : "R3", "divExc", divExc, expDiv, bad);
      if (wrEn != expWr) mis("R6", "wrEn", wrEn, expWr, bad);
      if (quoOut != q[7:0]) mis("R1", "quotient", longint'($signed(quoOut)), q, bad);
      if (remOut != rm[7:0]) mis("R2", "remainder", longint'($signed(remOut)), rm, bad);
      if (expWr && remIdx != r) mis("R7", "remIdx", remIdx, r, bad);
      if (expWr && quoIdx != (r | 4'd1)) mis("R7", "quoIdx", quoIdx, r | 4'd1, bad);
      @(negedge clk);
      if (done) mis("R8", "done longer than one cycle", done, 0, bad);
    end
    if (bad) failCount++;
  endtask

  initial begin
    #(8 * 190000);
    $display("FAIL watchdog: actual timeout expected completion");
    failCount++;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    int opIdx;
    lcg = 32'h1234_5678;
    opIdx = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    vecCount++;
    if (busy || done || wrEn || divExc || specExc) begin
      $display("FAIL R10 reset outputs: actual %0b%0b%0b%0b%0b expected 00000",
               busy, done, wrEn, divExc, specExc);
      failCount++;
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3 corner: the most negative quotient's positive twin
    runOp(16'sh0080 * -1, -8'sd1, 4'd4, 1'b0);
    runOp(-16'sd128, 8'sd1, 4'd2, 1'b0);

    // sweep every divisor (R1 R2 R3 R4 R8)
    for (int bi = 0; bi < 256; bi++) begin
      logic signed [7:0] b;
      int bInt;
      b = bi[7:0];
      bInt = int'(b);
      for (int k = 0; k < 24; k++) begin
        logic signed [15:0] a;
        unique case (k)
          0: a = -16'sd32768;
          1: a = 16'sd32767;
          2: a = 16'sd0;
          3: a = 16'sd1;
          4: a = -16'sd1;
          5: a = 16'(bInt * 127);
          6: a = 16'(bInt * 128);
          7: a = 16'(bInt * -128);
          8: a = 16'(bInt * -129);
          9: a = 16'(bInt * 127 + 1);
          default: begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            a = lcg[30:15];
          end
        endcase
        runOp(a, b, RW'((opIdx % 8) * 2), 1'b0);
        opIdx++;
      end
    end

    // R5: odd register numbers take priority over divide problems
    runOp(16'sd100, 8'sd7, 4'd1, 1'b0);
    runOp(16'sd100, 8'sd0, 4'd3, 1'b0);
    runOp(-16'sd32768, -8'sd1, 4'd15, 1'b0);
    runOp(-16'sd50, 8'sd3, 4'd9, 1'b0);

    // R9: start pulses while busy are ignored
    runOp(-16'sd1000, 8'sd9, 4'd6, 1'b1);
    runOp(16'sd12345, -8'sd100, 4'd8, 1'b1);
    runOp(16'sd127, -8'sd1, 4'd0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule